// File: doc/BRIEF.md
# Four-Lane Pipelined Multiply-Accumulate Filter

This block is the arithmetic core of a small image filter. Four lanes each multiply a 10-bit signed sample by an 11-bit signed weight. The four products are added together, and that sum either starts a fresh 25-bit running total or is added to the total already held. A 16-bit word is then taken from the total, with optional rounding, at one of four bit positions. An output register holds that word and can be frozen. An enable that does not use the clock switches the output pins to high impedance, so several blocks can share one bus.

Samples, weights and controls are all captured on the rising clock edge. Results appear a fixed five edges later, and a new set of operands can be accepted on every edge. The datapath has no valid/ready handshake, so it never applies back-pressure. The stream is paced entirely by the clock: every edge takes in one operand set, and every edge (unless the output is frozen) produces one result. Operands can be two's complement integers, or fractions in which the extra sign bit of each product is shifted out.

Top module: `mac4_filter`

## Requirements
- R1: A synchronous reset (`rst` high at an edge) clears every pipeline register, the running total and the output register, so `out_word` reads 0 after that edge while `out_oe` is 1.
- R2: In integer mode (`frac_mode`=0) each lane forms the exact signed product of its sample and weight. The four products are summed with sign extension.
- R3: A lane's sample register loads only at an edge where that lane's bit of `din_en` is 1. Otherwise it keeps its old sample, which then keeps taking part in later products. Lane i uses bit i of `din_en`, bits [10i+9:10i] of `din` and bits [11i+10:11i] of `coef`. Weights are captured at every edge.
- R4: In fractional mode (`frac_mode`=1) each lane product is doubled (shifted left one bit) before summation.
- R5: With `acc_add`=1 the running total becomes its previous value plus the new sum. With `acc_add`=0 it becomes the new sum. The total is 25 bits and wraps modulo 2^25.
- R6: Field code k on `fld_sel` (0 to 3) selects bits [3k+15:3k] of the total as the output word.
- R7: With `rnd_en`=1 and k>0, 2^(3k-1) is added to the total (modulo 2^25, no saturation) before the field is taken. With k=0, or with `rnd_en`=0, nothing is added.
- R8: Operands and controls presented before edge n determine `out_word` after edge n+4. That is five edges counting edge n.
- R9: `out_load`=1 lets the output register take the new word. With `out_load`=0 it keeps its previous value. Like the other controls, `out_load` is aligned to the operands presented with it.
- R10: `out_oe`=1 drives the output register onto `out_word`. `out_oe`=0 puts every bit of `out_word` at high impedance at once, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything is captured on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din_en | input | 4 | Per-lane sample load enable |
| din | input | 40 | Four 10-bit signed samples, lane 0 in the low bits |
| coef | input | 44 | Four 11-bit signed weights, lane 0 in the low bits |
| frac_mode | input | 1 | 1: fractional operands (products doubled) |
| acc_add | input | 1 | 1: add sum to running total; 0: load sum |
| fld_sel | input | 2 | Output field code k, low bit 3k |
| rnd_en | input | 1 | 1: round at the selected field |
| out_load | input | 1 | 1: output register updates; 0: holds |
| out_oe | input | 1 | Asynchronous output drive enable |
| out_word | output | 16 | Result word, high impedance when not enabled |

## Verification
The first pattern sets a single lane to each extreme sample and weight while the other lanes carry zero. This separates sign handling and product width per lane from any fault in summation or lane wiring. Pseudo-random operands across all lanes, with fractional mode, field code and rounding varied each cycle, tell a correct shift, field position and half-LSB constant apart from off-by-one variants. Long runs of the largest products in accumulate mode cross the 2^25 wrap in both directions and show whether the total grows and wraps. Random lane enables, random output freezing and toggling of the drive enable between edges each isolate one piece of control: a stale sample, a missed hold, or a clocked (rather than asynchronous) bus release.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
  localparam int unsigned FSEL_W = 2;

  // controls that travel down to the output stage
  typedef struct packed {
    logic [FSEL_W-1:0] fsel;
    logic              rnd;
    logic              load;
  } outctl_t;
endpackage

// File: rtl/mac4_delay.sv
module mac4_delay #(
  parameter int W = 1,
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < N; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/mac4_lane.sv
module mac4_lane #(
  parameter int DATA_W = 10,
  parameter int COEF_W = 11
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            load_en,
  input  logic                            frac_q,
  input  logic [DATA_W-1:0]               d_in,
  input  logic [COEF_W-1:0]               c_in,
  output logic [DATA_W+COEF_W:0]          prod_q
);
  localparam int FULL_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] dat_q;
  logic signed [COEF_W-1:0] cof_q;
  logic signed [FULL_W-1:0] full;

  assign full = dat_q * cof_q;

  // stage 1: operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      cof_q <= '0;
    end else begin
      if (load_en) dat_q <= d_in;
      cof_q <= c_in;
    end
  end

  // stage 2: product, optionally doubled for fractional operands
  always_ff @(posedge clk) begin
    if (rst)         prod_q <= '0;
    else if (frac_q) prod_q <= {full, 1'b0};
    else             prod_q <= {full[FULL_W-1], full};
  end
endmodule

// File: rtl/mac4_accum.sv
module mac4_accum #(
  parameter int LANES  = 4,
  parameter int PROD_W = 22,
  parameter int ACC_W  = 25
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*PROD_W-1:0]   prod_vec,
  input  logic                      add_q,
  output logic signed [ACC_W-1:0]   acc_q
);
  localparam int SUM_W = PROD_W + $clog2(LANES);

  logic signed [SUM_W-1:0] sum_c;
  logic signed [SUM_W-1:0] sum_q;

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < LANES; i++)
      sum_c = sum_c + SUM_W'($signed(prod_vec[i*PROD_W +: PROD_W]));
  end

  // stage 3: lane sum; stage 4: running total
  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
      acc_q <= '0;
    end else begin
      sum_q <= sum_c;
      acc_q <= add_q ? acc_q + ACC_W'(sum_q) : ACC_W'(sum_q);
    end
  end
endmodule

// File: rtl/mac4_outstage.sv
module mac4_outstage
  import mac4_pkg::*;
#(
  parameter int ACC_W = 25,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] acc_in,
  input  outctl_t          ctl,
  output logic [OUT_W-1:0] out_q
);
  localparam int CODES = 1 << FSEL_W;
  localparam int STEP  = (ACC_W - OUT_W) / (CODES - 1);

  logic [OUT_W-1:0] cand [CODES];

  for (genvar k = 0; k < CODES; k++) begin : g_fld
    if (k == 0) begin : g_plain
      assign cand[k] = acc_in[OUT_W-1:0];
    end else begin : g_rnd
      localparam int LSB = k * STEP;
      localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (LSB - 1);
      assign cand[k] = OUT_W'((acc_in + (ctl.rnd ? HALF : '0)) >> LSB);
    end
  end

  // stage 5: output register with hold
  always_ff @(posedge clk) begin
    if (rst)           out_q <= '0;
    else if (ctl.load) out_q <= cand[ctl.fsel];
  end
endmodule

// File: rtl/mac4_filter.sv
module mac4_filter
  import mac4_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DATA_W = 10,
  parameter int COEF_W = 11,
  parameter int ACC_W  = 25,
  parameter int OUT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES-1:0]          din_en,
  input  logic [LANES*DATA_W-1:0]   din,
  input  logic [LANES*COEF_W-1:0]   coef,
  input  logic                      frac_mode,
  input  logic                      acc_add,
  input  logic [FSEL_W-1:0]         fld_sel,
  input  logic                      rnd_en,
  input  logic                      out_load,
  input  logic                      out_oe,
  output logic [OUT_W-1:0]          out_word
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int OCTL_W = $bits(outctl_t);

  logic                     frac_q;
  logic                     add_q;
  outctl_t                  octl_in;
  outctl_t                  octl_q;
  logic [LANES*PROD_W-1:0]  prod_vec;
  logic signed [ACC_W-1:0]  acc_q;
  logic [OUT_W-1:0]         out_q;

  // control alignment: frac used at stage 2, add at stage 4, output controls at stage 5
  mac4_delay #(.W(1), .N(1)) u_frac (
    .clk(clk), .rst(rst), .d(frac_mode), .q(frac_q)
  );
  mac4_delay #(.W(1), .N(3)) u_add (
    .clk(clk), .rst(rst), .d(acc_add), .q(add_q)
  );

  assign octl_in = '{fsel: fld_sel, rnd: rnd_en, load: out_load};

  mac4_delay #(.W(OCTL_W), .N(4)) u_octl (
    .clk(clk), .rst(rst), .d(octl_in), .q(octl_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    mac4_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .load_en(din_en[i]),
      .frac_q (frac_q),
      .d_in   (din[i*DATA_W +: DATA_W]),
      .c_in   (coef[i*COEF_W +: COEF_W]),
      .prod_q (prod_vec[i*PROD_W +: PROD_W])
    );
  end

  mac4_accum #(.LANES(LANES), .PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .prod_vec(prod_vec), .add_q(add_q), .acc_q(acc_q)
  );

  mac4_outstage #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .acc_in(acc_q), .ctl(octl_q), .out_q(out_q)
  );

  assign out_word = out_oe ? out_q : 'z;
endmodule

// File: rtl/mac4_filter_chk.sv
module mac4_filter_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 10,
  parameter int ACC_W  = 25,
  parameter int OUT_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        din_en,
  input logic [LANES*DATA_W-1:0] din,
  input logic                    acc_add,
  input logic                    out_load,
  input logic [1:0]              fld_sel,
  input logic                    rnd_en,
  input logic [ACC_W-1:0]        acc_q,
  input logic [OUT_W-1:0]        out_q
);
  logic [2:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)                warm_cnt <= '0;
    else if (warm_cnt != 7) warm_cnt <= warm_cnt + 3'd1;
  end
  assign warm = (warm_cnt >= 3'd6);

  // R1: the edge after a reset leaves total and output at zero
  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (acc_q == '0 && out_q == '0));

  // R5: adding an all-zero sum leaves the running total unchanged
  a_r5_add_zero_keeps: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(acc_add, 4) && $past(din_en, 4) == '1 && $past(din, 4) == '0)
    |-> $stable(acc_q));

  // R8: zero samples in every lane, load mode, plain field 0 -> zero five edges later
  a_r8_zero_after_five: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(din_en, 5) == '1 && $past(din, 5) == '0 && !$past(acc_add, 5)
     && $past(out_load, 5) && $past(fld_sel, 5) == 2'd0 && !$past(rnd_en, 5))
    |-> out_q == '0);

  // R9: a deasserted load freezes the output register
  a_r9_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    (warm && !$past(out_load, 5)) |-> $stable(out_q));
endmodule

bind mac4_filter mac4_filter_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .din_en(din_en), .din(din), .acc_add(acc_add),
  .out_load(out_load), .fld_sel(fld_sel), .rnd_en(rnd_en),
  .acc_q(acc_q), .out_q(out_q)
);

// File: tb/sim_mac4_filter.sv
`timescale 1ns/1ps
module sim_mac4_filter;
  localparam int DW = 10;
  localparam int CW = 11;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  din_en = '0;
  logic [39:0] din = '0;
  logic [43:0] coef = '0;
  logic        frac_mode = 1'b0, acc_add = 1'b0, rnd_en = 1'b0;
  logic        out_load = 1'b1, out_oe = 1'b1;
  logic [1:0]  fld_sel = '0;
  wire  [15:0] out_word;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  int d[4], c[4], md[4];
  logic signed [24:0] macc;
  logic [15:0] mout;
  logic [15:0] expv [DEPTH];
  string tags [DEPTH];
  string tag;
  int unsigned rs = 32'h1234_5678;

  always #2.5 clk = ~clk;

  mac4_filter u0 (
    .clk(clk), .rst(rst), .din_en(din_en), .din(din), .coef(coef),
    .frac_mode(frac_mode), .acc_add(acc_add), .fld_sel(fld_sel),
    .rnd_en(rnd_en), .out_load(out_load), .out_oe(out_oe), .out_word(out_word)
  );

  function automatic int unsigned nxt();
    rs ^= rs << 13;
    rs ^= rs >> 17;
    rs ^= rs << 5;
    return rs;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", t, act, exp, cyc);
    end
  endtask

  task automatic drive();
    for (int i = 0; i < 4; i++) begin
      din[i*DW +: DW]  = d[i][DW-1:0];
      coef[i*CW +: CW] = c[i][CW-1:0];
    end
  endtask

  // reference model from the requirements, one issue per edge
  task automatic model();
    int sum = 0;
    int k = int'(fld_sel);
    logic [24:0] v;
    for (int i = 0; i < 4; i++) begin
      int p;
      if (din_en[i]) md[i] = d[i];          // R3
      p = md[i] * c[i];                     // R2
      if (frac_mode) p = p * 2;             // R4
      sum += p;
    end
    macc = acc_add ? macc + sum[24:0] : sum[24:0];   // R5
    v = macc + ((rnd_en && k > 0) ? (25'd1 << (3*k - 1)) : 25'd0);  // R7
    if (out_load) mout = 16'(v >> (3*k));   // R6, R9
    expv[cyc % DEPTH] = mout;
    tags[cyc % DEPTH] = tag;
  endtask

  task automatic tick();
    drive();
    model();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (cyc >= 5) chk(out_word, expv[(cyc-5) % DEPTH], tags[(cyc-5) % DEPTH]);  // R8
  endtask

  task automatic rnd_ops();
    for (int i = 0; i < 4; i++) begin
      int unsigned r = nxt();
      d[i] = int'($signed(r[9:0]));
      c[i] = int'($signed(r[26:16]));
    end
  endtask

  initial begin
    int dl[7] = '{-512, -511, -1, 0, 1, 255, 511};
    int cl[6] = '{-1024, -1023, -1, 0, 1, 1023};
    @(negedge clk);
    // R1: reset holds output at zero despite active operands
    for (int i = 0; i < 4; i++) begin d[i] = 300; c[i] = 700; end
    din_en = '1; drive();
    for (int n = 0; n < 3; n++) begin
      @(posedge clk); @(negedge clk);
      chk(out_word, 16'h0000, "R1 reset");
    end
    for (int i = 0; i < 4; i++) begin md[i] = 0; d[i] = 0; c[i] = 0; end
    macc = '0; mout = '0; cyc = 0;
    rst = 1'b0;

    // single-lane corner products, integer mode
    tag = "R2 R6 R8 corner product";
    for (int ln = 0; ln < 4; ln++)
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 6; b++) begin
          for (int i = 0; i < 4; i++) begin d[i] = 0; c[i] = cl[b]; end
          d[ln] = dl[a];
          din_en = '1; frac_mode = 0; acc_add = 0; rnd_en = 0; out_load = 1;
          fld_sel = 2'((a + b + ln) % 4);
          tick();
        end

    // random operands, fractional mode, fields and rounding
    tag = "R4 R6 R7 random mix";
    for (int n = 0; n < 400; n++) begin
      int unsigned r = nxt();
      rnd_ops();
      din_en = '1; acc_add = 0; out_load = 1;
      frac_mode = r[0]; rnd_en = r[1]; fld_sel = r[3:2];
      tick();
    end

    // accumulation runs crossing the wrap in both directions
    tag = "R5 accumulate wrap";
    for (int rep = 0; rep < 2; rep++)
      for (int n = 0; n < 18; n++) begin
        for (int i = 0; i < 4; i++) begin
          d[i] = rep ? 511 : -512; c[i] = -1024;
        end
        din_en = '1; frac_mode = 1; rnd_en = n[0]; fld_sel = 2'(n % 4);
        acc_add = (n != 0); out_load = 1;
        tick();
      end
    for (int n = 0; n < 100; n++) begin
      int unsigned r = nxt();
      rnd_ops();
      din_en = '1; frac_mode = r[0]; rnd_en = r[1]; fld_sel = r[3:2];
      acc_add = (r[6:4] != 0); out_load = 1;
      tick();
    end

    // per-lane enables
    tag = "R3 lane enable";
    for (int n = 0; n < 200; n++) begin
      int unsigned r = nxt();
      rnd_ops();
      din_en = r[3:0]; frac_mode = r[4]; rnd_en = r[5]; fld_sel = r[7:6];
      acc_add = 0; out_load = 1;
      tick();
    end

    // output hold, with drive-enable toggles in between edges
    tag = "R9 output hold";
    for (int n = 0; n < 200; n++) begin
      int unsigned r = nxt();
      rnd_ops();
      din_en = '1; frac_mode = r[0]; rnd_en = r[1]; fld_sel = r[3:2];
      acc_add = r[4]; out_load = (r[6:5] == 0);
      tick();
      if (n % 40 == 7) begin
        out_oe = 1'b0; #1;
        checks++;
        if (out_word !== 16'bz) begin
          errors++;
          $display("FAIL R10 release: actual %h expected zzzz", out_word);
        end
        out_oe = 1'b1; #1;
        if (cyc >= 5) chk(out_word, expv[(cyc-5) % DEPTH], "R10 drive restore");
      end
    end

    // R1: reset clears a nonzero state
    for (int i = 0; i < 4; i++) begin d[i] = 400; c[i] = 900; end
    din_en = '1; acc_add = 1; out_load = 1; drive();
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_word, 16'h0000, "R1 reset from running state");
    out_load = 0;
    @(posedge clk); @(negedge clk);
    chk(out_word, 16'h0000, "R1 reset held");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R8: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule